// File: doc/BRIEF.md
# Single-Cycle Four-Class Integer Processor

This block is a 32-bit processor that completes one instruction per clock. On every rising edge it has already fetched the word addressed by its program counter from an internal instruction store, split it into fields, produced a set of control strobes from the 6-bit opcode, read two source registers, run the ALU and, where the instruction asks for it, touched an internal data store. It then commits a register write-back or a memory write and moves the program counter. Three register-to-register operations share opcode 0 and are told apart by the function field: add, subtract and signed set-less-than. The other three instructions are word load, word store and branch-if-equal.

Both stores are word-indexed arrays. A load port fills them while reset is held, and the bench uses that port to place the program and the initial data. The write-back and store strobes, with their addresses and data, appear on output ports so that every committed effect can be seen. Instructions outside the six listed act as no-ops.

Top module: `sc_cpu_top`

## Requirements
- R1: While `rst` is high, `pc` is 0, `rfWe` and `dmWe` are 0, and all 32 registers are cleared. The first instruction after `rst` falls is fetched from byte address 0.
- R2: Opcode 0 with function code 32 writes rs+rt into the register named by bits 15:11 (rd). With function code 34 it writes rs−rt. Both wrap modulo 2^32. rs is bits 25:21 and rt is bits 20:16.
- R3: Opcode 0 with function code 42 writes 1 to rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R4: Opcode 35 writes into rt the data word at byte address rs + sign-extended bits 15:0.
- R5: Opcode 43 stores rt to the data word at byte address rs + sign-extended bits 15:0. It asserts `dmWe` and leaves `rfWe` low.
- R6: Opcode 4 compares rs and rt. If they are equal, the next `pc` is pc+4 plus the sign-extended bits 15:0 shifted left by two. If not, the next `pc` is pc+4. Neither write strobe is asserted.
- R7: Register 0 always reads as zero. A write aimed at it, from an arithmetic result or a load, has no effect.
- R8: Any other opcode, and opcode 0 with any other function code, writes nothing: `rfWe` and `dmWe` stay low.
- R9: Every instruction except a taken branch advances `pc` by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Writes `loadData` into a store on this edge (used while in reset) |
| loadToData | input | 1 | 1 selects the data store, 0 the instruction store |
| loadAddr | input | 6 | Word index for the load port |
| loadData | input | 32 | Word to place |
| pc | output | 32 | Byte address of the instruction now executing |
| rfWe | output | 1 | Register write-back commits on the next edge |
| rfWaddr | output | 5 | Destination register of the write-back |
| rfWdata | output | 32 | Write-back value |
| dmWe | output | 1 | Data store write commits on the next edge |
| dmAddr | output | 32 | Byte address computed for the data store |
| dmWdata | output | 32 | Store value (rt) |

## Verification
The assertions take for granted that the load port is used only while `rst` is high. An update of the program counter or of a store at the same time as loading would otherwise break the step and branch properties. They also take for granted that every data address the program forms is word-aligned and inside the data store, and that branch targets stay inside the instruction store. The stimulus keeps within this: it fills both stores completely under reset, uses only multiples of four for base plus offset, and ends each program in a branch-to-self so that fetch never runs past the loaded code.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;
  localparam logic [5:0] OPC_BEQ   = 6'd4;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_SUB  = 2'd1,
    ALU_SLT  = 2'd2,
    ALU_ZERO = 2'd3
  } aluFn_t;

  typedef struct packed {
    logic       dstFromRd;   // destination from rd (else rt)
    logic       opBFromImm;  // second ALU operand is the immediate
    logic       wbFromMem;   // write-back value from data store
    logic       regWe;
    logic       memRe;
    logic       memWe;
    logic       isBranch;
    logic [1:0] aluMode;     // 00 add, 01 subtract, 10 by function code
    aluFn_t     aluFn;
  } ctrlStrobes_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import sc_cpu_pkg::*;
(
  input  logic [1:0] aluMode,
  input  logic [5:0] funct,
  output aluFn_t     aluFn,
  output logic       fnValid
);

  always_comb begin
    aluFn   = ALU_ZERO;
    fnValid = 1'b0;
    unique case (aluMode)
      2'b00: begin aluFn = ALU_ADD; fnValid = 1'b1; end
      2'b01: begin aluFn = ALU_SUB; fnValid = 1'b1; end
      2'b10: begin
        case (funct)
          FN_ADD:  begin aluFn = ALU_ADD; fnValid = 1'b1; end
          FN_SUB:  begin aluFn = ALU_SUB; fnValid = 1'b1; end
          FN_SLT:  begin aluFn = ALU_SLT; fnValid = 1'b1; end
          default: begin aluFn = ALU_ZERO; fnValid = 1'b0; end
        endcase
      end
      default: begin aluFn = ALU_ZERO; fnValid = 1'b0; end
    endcase
  end

endmodule

// File: rtl/cpu_control.sv
module cpu_control
  import sc_cpu_pkg::*;
(
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  output ctrlStrobes_t ctrl
);

  ctrlStrobes_t baseCtrl;
  aluFn_t       decodedFn;
  logic         fnValid;

  // Fields that do not matter for an opcode are tied to 0.
  always_comb begin
    baseCtrl = '0;
    case (opcode)
      OPC_REG: begin
        baseCtrl.dstFromRd = 1'b1;
        baseCtrl.regWe     = 1'b1;
        baseCtrl.aluMode   = 2'b10;
      end
      OPC_LOAD: begin
        baseCtrl.opBFromImm = 1'b1;
        baseCtrl.wbFromMem  = 1'b1;
        baseCtrl.regWe      = 1'b1;
        baseCtrl.memRe      = 1'b1;
      end
      OPC_STORE: begin
        baseCtrl.opBFromImm = 1'b1;
        baseCtrl.memWe      = 1'b1;
      end
      OPC_BEQ: begin
        baseCtrl.isBranch = 1'b1;
        baseCtrl.aluMode  = 2'b01;
      end
      default: baseCtrl.aluMode = 2'b11;
    endcase
  end

  alu_decode u_aluDec (
    .aluMode (baseCtrl.aluMode),
    .funct   (funct),
    .aluFn   (decodedFn),
    .fnValid (fnValid)
  );

  always_comb begin
    ctrl       = baseCtrl;
    ctrl.aluFn = decodedFn;
    ctrl.regWe = baseCtrl.regWe & fnValid;
  end

endmodule

// File: rtl/reg_file.sv
module reg_file #(
  parameter int NREG  = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddrA,
  input  logic [AW-1:0]    raddrB,
  output logic [WIDTH-1:0] rdataA,
  output logic [WIDTH-1:0] rdataB
);

  logic [WIDTH-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdataA = (raddrA == '0) ? '0 : regs[raddrA];
  assign rdataB = (raddrB == '0) ? '0 : regs[raddrB];

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import sc_cpu_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  parameter int LOAD_AW    = 6,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       ctrl,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  output logic [31:0]        instr,
  output logic [31:0]        pc,
  output logic               rfWe,
  output logic [4:0]         rfWaddr,
  output logic [31:0]        rfWdata,
  output logic               dmWe,
  output logic [31:0]        dmAddr,
  output logic [31:0]        dmWdata
);

  logic [31:0] imem [IMEM_DEPTH];
  logic [31:0] dmem [DMEM_DEPTH];

  logic [4:0]  rsIdx, rtIdx, rdIdx;
  logic [31:0] immExt, branchOffs, rdA, rdB, opB, aluRes, memRd;
  logic [31:0] pcPlus4, pcNext;
  logic        aluZero;
  logic        unusedBits;

  assign instr  = imem[pc[IAW+1:2]];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign immExt = {{16{instr[15]}}, instr[15:0]};
  assign branchOffs = {immExt[29:0], 2'b00};

  reg_file #(.NREG(32), .WIDTH(32)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (rfWe),
    .waddr  (rfWaddr),
    .wdata  (rfWdata),
    .raddrA (rsIdx),
    .raddrB (rtIdx),
    .rdataA (rdA),
    .rdataB (rdB)
  );

  assign opB = ctrl.opBFromImm ? immExt : rdB;

  always_comb begin
    case (ctrl.aluFn)
      ALU_ADD: aluRes = rdA + opB;
      ALU_SUB: aluRes = rdA - opB;
      ALU_SLT: aluRes = {31'd0, $signed(rdA) < $signed(opB)};
      default: aluRes = '0;
    endcase
  end
  assign aluZero = (aluRes == '0);

  assign memRd   = ctrl.memRe ? dmem[aluRes[DAW+1:2]] : '0;
  assign rfWe    = ctrl.regWe & ~rst;
  assign rfWaddr = ctrl.dstFromRd ? rdIdx : rtIdx;
  assign rfWdata = ctrl.wbFromMem ? memRd : aluRes;
  assign dmWe    = ctrl.memWe & ~rst;
  assign dmAddr  = aluRes;
  assign dmWdata = rdB;

  assign pcPlus4 = pc + 32'd4;
  assign pcNext  = (ctrl.isBranch && aluZero) ? pcPlus4 + branchOffs : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr[IAW-1:0]] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (loadEn && loadToData)  dmem[loadAddr[DAW-1:0]] <= loadData;
    else if (dmWe)             dmem[aluRes[DAW+1:2]]   <= rdB;
  end

  assign unusedBits = ^ctrl.aluMode;

  // R9: without a taken branch the PC steps by one word
  p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.isBranch || rdA != rdB) |=> pc == $past(pc) + 32'd4);

  // R6: equal operands on a branch redirect to the offset target
  p_branch_target_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.isBranch && rdA == rdB) |=> pc == $past(pc) + 32'd4 + $past(branchOffs));

  // R5: a store never also writes back
  p_store_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWe |-> !ctrl.regWe);

  // R8: at most one kind of side effect per instruction
  p_one_effect_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.regWe, ctrl.memWe, ctrl.isBranch}));

  // R4: a data-store read always feeds the write-back into rt
  p_load_path_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl.memRe |-> (ctrl.wbFromMem && !ctrl.dstFromRd && ctrl.opBFromImm));

endmodule

// File: rtl/sc_cpu_top.sv
module sc_cpu_top
  import sc_cpu_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int LOAD_AW = $clog2(IMEM_DEPTH > DMEM_DEPTH ? IMEM_DEPTH : DMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  output logic [31:0]        pc,
  output logic               rfWe,
  output logic [4:0]         rfWaddr,
  output logic [31:0]        rfWdata,
  output logic               dmWe,
  output logic [31:0]        dmAddr,
  output logic [31:0]        dmWdata
);

  ctrlStrobes_t ctrl;
  logic [31:0]  instr;

  cpu_control u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  cpu_datapath #(
    .IMEM_DEPTH (IMEM_DEPTH),
    .DMEM_DEPTH (DMEM_DEPTH),
    .LOAD_AW    (LOAD_AW)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .instr      (instr),
    .pc         (pc),
    .rfWe       (rfWe),
    .rfWaddr    (rfWaddr),
    .rfWdata    (rfWdata),
    .dmWe       (dmWe),
    .dmAddr     (dmAddr),
    .dmWdata    (dmWdata)
  );

endmodule

// File: tb/tb_sc_cpu_top.sv
module tb_sc_cpu_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadToData = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [31:0] pc;
  logic        rfWe;
  logic [4:0]  rfWaddr;
  logic [31:0] rfWdata;
  logic        dmWe;
  logic [31:0] dmAddr;
  logic [31:0] dmWdata;

  always #4ns clk = ~clk;

  sc_cpu_top dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadData(loadData), .pc(pc), .rfWe(rfWe),
    .rfWaddr(rfWaddr), .rfWdata(rfWdata), .dmWe(dmWe), .dmAddr(dmAddr),
    .dmWdata(dmWdata)
  );

  typedef struct {
    logic [31:0] pc;
    logic        rfWe;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        dmWe;
    logic [31:0] da;
    logic [31:0] dd;
    string       tag;
    string       pcTag;
  } expItem_t;

  expItem_t    expQ[$];
  int          tests = 0;
  int          fails = 0;
  bit          monOn = 1'b0;
  bit          done  = 1'b0;

  logic [31:0] prog  [64];
  logic [31:0] mdata [64];
  logic [31:0] mregs [32];
  logic [31:0] mpc;
  string       mpcTag;

  function automatic logic [31:0] rOp(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  function automatic logic [31:0] iOp(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: reference model of the instruction set, one expected item per cycle
  task automatic modelStep();
    expItem_t    e;
    logic [31:0] w, a, b, sx, nxt, ad;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    w  = prog[mpc[7:2]];
    op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; fn = w[5:0];
    sx = {{16{w[15]}}, w[15:0]};
    a  = mregs[rs]; b = mregs[rt];
    e = '{pc: mpc, rfWe: 1'b0, wa: '0, wd: '0, dmWe: 1'b0, da: '0, dd: '0,
          tag: "R8", pcTag: mpcTag};
    nxt = mpc + 32'd4;
    mpcTag = "R9";
    case (op)
      6'd0: begin
        case (fn)
          6'd32: begin e.rfWe = 1; e.wa = rd; e.wd = a + b; e.tag = "R2"; end
          6'd34: begin e.rfWe = 1; e.wa = rd; e.wd = a - b; e.tag = "R2"; end
          6'd42: begin e.rfWe = 1; e.wa = rd; e.wd = ($signed(a) < $signed(b)) ? 1 : 0; e.tag = "R3"; end
          default: ;
        endcase
        if (e.rfWe && rd == 0) e.tag = "R7";
      end
      6'd35: begin
        ad = a + sx;
        e.rfWe = 1; e.wa = rt; e.wd = mdata[ad[7:2]];
        e.tag = (rt == 0) ? "R7" : "R4";
      end
      6'd43: begin
        ad = a + sx;
        e.dmWe = 1; e.da = ad; e.dd = b; e.tag = "R5";
        mdata[ad[7:2]] = b;
      end
      6'd4: begin
        e.tag = "R6";
        if (a == b) begin nxt = mpc + 32'd4 + {sx[29:0], 2'b00}; mpcTag = "R6"; end
      end
      default: ;
    endcase
    if (e.rfWe && e.wa != 0) mregs[e.wa] = e.wd;
    mpc = nxt;
    expQ.push_back(e);
  endtask

  // Monitor: pops one expected item per cycle and compares at the ports
  always begin
    @(negedge clk);
    #2ns;
    if (monOn && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(pc == e.pc, e.pcTag, "pc", pc, e.pc);
      check(rfWe == e.rfWe, e.tag, "rfWe", {31'd0, rfWe}, {31'd0, e.rfWe});
      if (e.rfWe) begin
        check(rfWaddr == e.wa, e.tag, "rfWaddr", {27'd0, rfWaddr}, {27'd0, e.wa});
        check(rfWdata == e.wd, e.tag, "rfWdata", rfWdata, e.wd);
      end
      check(dmWe == e.dmWe, e.tag, "dmWe", {31'd0, dmWe}, {31'd0, e.dmWe});
      if (e.dmWe) begin
        check(dmAddr == e.da, e.tag, "dmAddr", dmAddr, e.da);
        check(dmWdata == e.dd, e.tag, "dmWdata", dmWdata, e.dd);
      end
    end
  end

  task automatic runProgram(int cycles);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check(pc == 0, "R1", "pc in reset", pc, 0);
    check(rfWe == 0 && dmWe == 0, "R1", "strobes in reset", {30'd0, rfWe, dmWe}, 0);
    for (int i = 0; i < 64; i++) begin
      loadEn = 1; loadToData = 0; loadAddr = i[5:0]; loadData = prog[i];
      @(negedge clk);
      loadToData = 1; loadData = mdata[i];
      @(negedge clk);
    end
    loadEn = 0;
    for (int i = 0; i < 32; i++) mregs[i] = '0;
    mpc = 0; mpcTag = "R1";
    for (int i = 0; i < cycles; i++) modelStep();
    @(negedge clk);
    rst = 1'b0;
    monOn = 1'b1;
    wait (expQ.size() == 0);
    monOn = 1'b0;
  endtask

  initial begin
    // Program A: arithmetic, loads, stores, register 0, unlisted codes
    for (int i = 0; i < 64; i++) begin
      prog[i] = iOp(4, 0, 0, -1);
      mdata[i] = 32'h1000_0000 + i * 32'h0101;
    end
    mdata[0] = 32'd7; mdata[1] = 32'hFFFF_FFFB; mdata[2] = 32'h7FFF_FFFF; mdata[3] = 32'd32;
    prog[0]  = iOp(35, 0, 1, 0);      // r1 = 7
    prog[1]  = iOp(35, 0, 2, 4);      // r2 = -5
    prog[2]  = iOp(35, 0, 3, 8);      // r3 = max positive
    prog[3]  = iOp(35, 0, 13, 12);    // r13 = 32
    prog[4]  = rOp(1, 2, 4, 32);      // R2 add
    prog[5]  = rOp(1, 2, 5, 34);      // R2 sub
    prog[6]  = rOp(2, 1, 6, 42);      // R3 -5 < 7 -> 1
    prog[7]  = rOp(1, 2, 7, 42);      // R3 7 < -5 -> 0
    prog[8]  = rOp(1, 1, 8, 42);      // R3 equal -> 0
    prog[9]  = rOp(3, 1, 9, 32);      // R2 wrap
    prog[10] = rOp(0, 3, 10, 34);     // R2 negate
    prog[11] = iOp(43, 13, 6, -8);    // R5 negative offset
    prog[12] = iOp(35, 13, 14, -8);   // R4 read back
    prog[13] = iOp(43, 0, 9, 20);     // R5
    prog[14] = iOp(35, 0, 21, 20);    // R4
    prog[15] = rOp(1, 1, 0, 32);      // R7 write to r0
    prog[16] = rOp(0, 0, 15, 32);     // R7 r0 still zero
    prog[17] = iOp(35, 0, 0, 0);      // R7 load into r0
    prog[18] = rOp(1, 0, 16, 34);     // R7 r1 - r0 = 7
    prog[19] = iOp(8, 0, 17, 5);      // R8 unlisted opcode
    prog[20] = rOp(17, 0, 18, 32);    // R8 r17 untouched
    prog[21] = rOp(1, 1, 19, 36);     // R8 unlisted function code
    prog[22] = rOp(19, 0, 20, 32);    // R8 r19 untouched
    prog[23] = iOp(63, 1, 2, 0);      // R8 unlisted opcode
    runProgram(30);

    // Program B: branch loop, taken and not-taken branches
    for (int i = 0; i < 64; i++) begin
      prog[i] = iOp(4, 0, 0, -1);
      mdata[i] = 32'h2000_0000 ^ i;
    end
    mdata[0] = 32'd3; mdata[1] = 32'd1;
    prog[0] = iOp(35, 0, 1, 0);       // r1 = 3
    prog[1] = iOp(35, 0, 2, 4);       // r2 = 1
    prog[2] = rOp(3, 1, 3, 32);       // r3 += r1
    prog[3] = rOp(1, 2, 1, 34);       // r1 -= 1
    prog[4] = iOp(4, 1, 0, 1);        // R6 exit when r1 == 0
    prog[5] = iOp(4, 0, 0, -4);       // R6 back to prog[2]
    prog[6] = iOp(4, 1, 2, 5);        // R6 not taken
    prog[7] = iOp(43, 0, 3, 8);       // R5 store sum
    prog[8] = iOp(35, 0, 4, 8);       // R4 load sum
    runProgram(30);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule